// File: doc/BRIEF.md
# Single-channel DMA mover with persistent read latch

This block is one DMA channel on a 32-bit memory bus. Software-style register writes program a source address, a destination address, a unit count and a control word. When the control word's enable bit goes from 0 to 1, the channel copies these values into private working registers. It then moves halfword or word units from source to destination, either at once or after an external trigger pulse.

Each unit is one read followed by one write on separate request/ready ports. A 32-bit data latch keeps the last value read. Sources in the low, unreadable region below 0x0200_0000 produce no read, and the unit writes whatever the latch already holds. A halfword read fills both halves of the latch. A halfword write picks its lane by rotating the latch right by the destination's byte offset.

Top module: `dma_latch_chan`

## Requirements
- R1: A write to the source register keeps 27 low bits when CHAN_ID is 0 and 28 bits otherwise. A write to the destination register keeps 28 bits when CHAN_ID is 3 and 27 bits otherwise.
- R2: The unit count is 16 bits wide when CHAN_ID is 3 and 14 bits wide otherwise. A programmed count of 0 runs the maximum count for that width (16383 by default).
- R3: Register select codes are 0 source, 1 destination, 2 count and 3 control. A 0-to-1 write of control bit 0 (enable) snapshots source, destination, count and the control fields. Writes to source, destination or count while the channel is busy do not change the transfer.
- R4: Control bits 2:1 are the start timing. Code 00 starts the transfer on the cycle after the enabling write. Any other code keeps the channel idle on the bus until a trig_i pulse. trig_i has no effect while the channel is not armed.
- R5: Control bit 3 selects word (1) or halfword (0). Word addresses on the bus have bits 1:0 cleared and step by 4. Halfword addresses have bit 0 cleared and step by 2. Bits 5:4 set the source adjust and bits 7:6 the destination adjust: 00 increment, 01 decrement, 10 or 11 fixed. The adjust applies after every unit.
- R6: A read is issued, and the latch updated, only when the aligned source is at or above 0x0200_0000. Otherwise no read occurs and the unit writes the current latch contents.
- R7: A halfword read takes rd_data_i[15:0] and places it in both halves of the latch.
- R8: A halfword write drives bits 15:0 of the latch rotated right by 8 times the destination's bits 1:0, with wr_data_o[31:16] zero. A word write drives the whole latch.
- R9: After reset the latch holds zero, busy_o is low and neither bus request is raised.
- R10: Each unit raises at most one read, then one write, never both at once. Each request holds its address and data until ready. After the last unit, busy_o falls and the enable bit clears, so a later enabling write starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| trig_i | input | 1 | Start pulse for armed, non-immediate transfers |
| busy_o | output | 1 | Transfer in progress |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Aligned read address |
| rd_word_o | output | 1 | Read size, 1 = word |
| rd_data_i | input | 32 | Read data |
| rd_ready_i | input | 1 | Read accepted, data valid |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Aligned write address |
| wr_word_o | output | 1 | Write size, 1 = word |
| wr_data_o | output | 32 | Write data |
| wr_ready_i | input | 1 | Write accepted |

## Verification
Word transfers from the readable region, with increment, decrement and fixed stepping, show that the alignment and step logic is right. A word read followed by halfword units from the low region, written at offsets 2 and 0, shows whether reads are suppressed and whether the rotation picks the correct lane. Halfword reads written at offset 2 can only match if the read value was mirrored. Register rewrites during a stalled transfer, a triggered start and a zero count separate the snapshot, the timing and the count-width behaviour.

// File: rtl/dma_latch_pkg.sv
package dma_latch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READ, ST_WRITE} dma_state_e;

  localparam logic [1:0] ADJ_INC = 2'b00;
  localparam logic [1:0] ADJ_DEC = 2'b01;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam logic [31:0] READ_FLOOR = 32'h0200_0000;

  typedef struct packed {
    logic [1:0] dst_adj;
    logic [1:0] src_adj;
    logic       word;
    logic [1:0] timing;
    logic       enable;
  } ctrl_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_latch_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int AW      = 32,
  parameter int CNT_W   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [31:0]      wdata_i,
  input  logic             done_i,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CNT_W-1:0] cnt_o,
  output ctrl_t            ctrl_o,
  output logic             en_rise_o,
  output logic             en_fall_o
);
  localparam logic [31:0] SRC_MASK = (CHAN_ID == 0) ? 32'h07FF_FFFF : 32'h0FFF_FFFF;
  localparam logic [31:0] DST_MASK = (CHAN_ID == 3) ? 32'h0FFF_FFFF : 32'h07FF_FFFF;

  ctrl_t ctrl_q;
  logic  ctrl_we;

  assign ctrl_we   = we_i && (sel_i == SEL_CTRL);
  assign en_rise_o = ctrl_we && wdata_i[0] && !ctrl_q.enable;
  assign en_fall_o = ctrl_we && !wdata_i[0];
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_o  <= '0;
      ctrl_q <= '0;
    end else begin
      if (done_i) ctrl_q.enable <= 1'b0;
      if (we_i) begin
        unique case (sel_i)
          SEL_SRC:  src_o  <= AW'(wdata_i & SRC_MASK);
          SEL_DST:  dst_o  <= AW'(wdata_i & DST_MASK);
          SEL_CNT:  cnt_o  <= wdata_i[CNT_W-1:0];
          default:  ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    adj_i,
  input  logic          word_i,
  output logic [AW-1:0] aligned_o,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] step;

  assign step      = word_i ? AW'(4) : AW'(2);
  assign aligned_o = word_i ? {addr_i[AW-1:2], 2'b00} : {addr_i[AW-1:1], 1'b0};

  always_comb begin
    unique case (adj_i)
      2'b00:   next_o = addr_i + step;
      2'b01:   next_o = addr_i - step;
      default: next_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_data_latch.sv
module dma_data_latch #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          word_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [1:0]    lane_i,
  output logic [DW-1:0] wr_data_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0]   latch_q;
  logic [2*DW-1:0] rot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   latch_q <= '0;
    else if (ld_i) latch_q <= word_i ? rd_data_i : {rd_data_i[HW-1:0], rd_data_i[HW-1:0]};
  end

  // rotate right by byte lane
  assign rot       = {latch_q, latch_q} >> {lane_i, 3'b000};
  assign wr_data_o = word_i ? latch_q : {{HW{1'b0}}, rot[HW-1:0]};
endmodule

// File: rtl/dma_latch_chan.sv
module dma_latch_chan
  import dma_latch_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int AW      = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          trig_i,
  output logic          busy_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_word_o,
  input  logic [31:0]   rd_data_i,
  input  logic          rd_ready_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_word_o,
  output logic [31:0]   wr_data_o,
  input  logic          wr_ready_i
);
  localparam int CNT_W = (CHAN_ID == 3) ? 16 : 14;
  localparam int DW    = 32;

  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  ctrl_t            ctrl_q, ctrl_new;
  logic             en_rise, en_fall, done;

  dma_state_e       state_q;
  logic [AW-1:0]    wk_addr [2];
  logic [1:0]       wk_adj  [2];
  logic [AW-1:0]    al_addr [2];
  logic [AW-1:0]    nx_addr [2];
  logic [CNT_W-1:0] cnt_wk;
  logic             word_wk;
  logic             readable, ld;

  assign ctrl_new = ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);

  dma_regs #(.CHAN_ID(CHAN_ID), .AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .done_i    (done),
    .src_o     (src_q),
    .dst_o     (dst_q),
    .cnt_o     (cnt_q),
    .ctrl_o    (ctrl_q),
    .en_rise_o (en_rise),
    .en_fall_o (en_fall)
  );

  // index 0 = source, 1 = destination
  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_addr_step #(.AW(AW)) u_step (
      .addr_i    (wk_addr[g]),
      .adj_i     (wk_adj[g]),
      .word_i    (word_wk),
      .aligned_o (al_addr[g]),
      .next_o    (nx_addr[g])
    );
  end

  assign readable = al_addr[0] >= AW'(READ_FLOOR);
  assign ld       = (state_q == ST_READ) && readable && rd_ready_i;
  assign done     = (state_q == ST_WRITE) && wr_ready_i && (cnt_wk == CNT_W'(1)) && !en_fall;

  dma_data_latch #(.DW(DW)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld),
    .word_i    (word_wk),
    .rd_data_i (rd_data_i),
    .lane_i    (al_addr[1][1:0]),
    .wr_data_o (wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wk_addr[0] <= '0;
      wk_addr[1] <= '0;
      wk_adj[0]  <= '0;
      wk_adj[1]  <= '0;
      cnt_wk     <= '0;
      word_wk    <= 1'b0;
    end else if (en_fall) begin
      state_q <= ST_IDLE;
    end else if (en_rise) begin
      wk_addr[0] <= src_q;
      wk_addr[1] <= dst_q;
      wk_adj[0]  <= ctrl_new.src_adj;
      wk_adj[1]  <= ctrl_new.dst_adj;
      word_wk    <= ctrl_new.word;
      cnt_wk     <= (cnt_q == '0) ? '1 : cnt_q;
      state_q    <= (ctrl_new.timing == 2'b00) ? ST_READ : ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT:  if (trig_i) state_q <= ST_READ;
        ST_READ:  if (!readable || rd_ready_i) state_q <= ST_WRITE;
        ST_WRITE: if (wr_ready_i) begin
          wk_addr[0] <= nx_addr[0];
          wk_addr[1] <= nx_addr[1];
          cnt_wk     <= cnt_wk - CNT_W'(1);
          state_q    <= (cnt_wk == CNT_W'(1)) ? ST_IDLE : ST_READ;
        end
        default: ;
      endcase
    end
  end

  assign busy_o    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign rd_req_o  = (state_q == ST_READ) && readable;
  assign rd_addr_o = al_addr[0];
  assign rd_word_o = word_wk;
  assign wr_req_o  = (state_q == ST_WRITE);
  assign wr_addr_o = al_addr[1];
  assign wr_word_o = word_wk;
endmodule

// File: rtl/dma_latch_chan_chk.sv
module dma_latch_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_word_o,
  input logic          rd_ready_i,
  input logic          wr_req_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_word_o,
  input logic [31:0]   wr_data_o,
  input logic          wr_ready_i
);
  a_r10_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  a_r10_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ready_i |=> rd_req_o && $stable(rd_addr_o));

  a_r10_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ready_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  a_r6_no_low_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o >= AW'(32'h0200_0000));

  a_r5_rd_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_word_o ? (rd_addr_o[1:0] == 2'b00) : !rd_addr_o[0]));

  a_r5_wr_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_word_o ? (wr_addr_o[1:0] == 2'b00) : !wr_addr_o[0]));

  a_r8_half_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_word_o |-> wr_data_o[31:16] == 16'h0);

  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o && !wr_req_o);
endmodule

bind dma_latch_chan dma_latch_chan_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_word_o  (rd_word_o),
  .rd_ready_i (rd_ready_i),
  .wr_req_o   (wr_req_o),
  .wr_addr_o  (wr_addr_o),
  .wr_word_o  (wr_word_o),
  .wr_data_o  (wr_data_o),
  .wr_ready_i (wr_ready_i)
);

// File: tb/dma_latch_chan_tb.sv
module dma_latch_chan_tb;
  localparam int CNT_MAX = 16383;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        trig = 1'b0;
  logic        busy, rd_req, rd_word, wr_req, wr_word;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] rd_data = '0;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int rd_n = 0, wr_n = 0;
  logic [31:0] rd_a [64];
  logic [31:0] wr_a [64];
  logic [31:0] wr_d [64];
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_en = 1'b0;
  logic [31:0] m_latch = '0;

  always #5 clk = ~clk;

  dma_latch_chan u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .reg_we_i (reg_we), .reg_sel_i (reg_sel), .reg_wdata_i (reg_wdata),
    .trig_i (trig), .busy_o (busy),
    .rd_req_o (rd_req), .rd_addr_o (rd_addr), .rd_word_o (rd_word),
    .rd_data_i (rd_data), .rd_ready_i (rd_ready),
    .wr_req_o (wr_req), .wr_addr_o (wr_addr), .wr_word_o (wr_word),
    .wr_data_o (wr_data), .wr_ready_i (wr_ready)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] ^ 16'hC3A5};
  endfunction

  // memory model and handshake log, driven off the active edge
  always @(negedge clk) begin
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = rd_req && !(stall_en && lfsr[0]);
    wr_ready = wr_req && !(stall_en && lfsr[1]);
    rd_data  = memf(rd_addr);
    if (rd_ready) begin
      if (rd_n < 64) rd_a[rd_n] = rd_addr;
      rd_n++;
    end
    if (wr_ready) begin
      if (wr_n < 64) begin
        wr_a[wr_n] = wr_addr;
        wr_d[wr_n] = wr_data;
      end
      wr_n++;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R10 watchdog act=%0d exp=<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    rd_n = 0; wr_n = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] mk_ctrl(input logic [1:0] dadj, input logic [1:0] sadj,
                                         input logic word, input logic [1:0] tim);
    return {dadj, sadj, word, tim, 1'b1};
  endfunction

  task automatic start(input logic [31:0] s, input logic [31:0] d, input int n, input logic [7:0] c);
    clear_log();
    reg_write(2'd0, s);
    reg_write(2'd1, d);
    reg_write(2'd2, n);
    reg_write(2'd3, {24'h0, c});
  endtask

  // independent model of the transfer; compares with the handshake log
  task automatic expect_xfer(input logic [31:0] src, input logic [31:0] dst, input int n,
                             input logic [7:0] c, input string tag);
    logic [31:0] s, d, sa, da, wd, rv, st;
    int units, nrd;
    bit word;
    word  = c[3];
    s     = src & 32'h07FF_FFFF;
    d     = dst & 32'h07FF_FFFF;
    units = (n == 0) ? CNT_MAX : n;
    nrd   = 0;
    st    = word ? 32'd4 : 32'd2;
    for (int u = 0; u < units; u++) begin
      sa = word ? (s & ~32'h3) : (s & ~32'h1);
      da = word ? (d & ~32'h3) : (d & ~32'h1);
      if (sa >= 32'h0200_0000) begin
        rv      = memf(sa);
        m_latch = word ? rv : {rv[15:0], rv[15:0]};
        if (nrd < 64) chk(rd_a[nrd] == sa, {tag, " rd addr"}, rd_a[nrd], sa);
        nrd++;
      end
      wd = word ? m_latch : {16'h0, (da[1] ? m_latch[31:16] : m_latch[15:0])};
      if (u < 64) begin
        chk(wr_a[u] == da, {tag, " wr addr"}, wr_a[u], da);
        chk(wr_d[u] == wd, {tag, " wr data"}, wr_d[u], wd);
      end
      if (c[5:4] == 2'b00) s = s + st; else if (c[5:4] == 2'b01) s = s - st;
      if (c[7:6] == 2'b00) d = d + st; else if (c[7:6] == 2'b01) d = d - st;
    end
    chk(rd_n == nrd, {tag, " read count"}, rd_n, nrd);
    chk(wr_n == units, {tag, " write count"}, wr_n, units);
    chk(!busy, {tag, " R10 busy clear"}, busy, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !rd_req && !wr_req, "R9 reset quiet", {busy, rd_req, wr_req}, 0);
  endtask

  task automatic t_reset_latch();
    logic [7:0] c;
    c = mk_ctrl(2'b00, 2'b00, 1'b0, 2'b00);
    start(32'h0000_1000, 32'h0300_0000, 2, c);
    wait_idle();
    expect_xfer(32'h0000_1000, 32'h0300_0000, 2, c, "R9 R6 zero latch");
  endtask

  task automatic t_word_inc();
    logic [7:0] c;
    c = mk_ctrl(2'b00, 2'b00, 1'b1, 2'b00);
    stall_en = 1'b1;
    start(32'h0300_0010, 32'h0400_0100, 4, c);
    wait_idle();
    stall_en = 1'b0;
    expect_xfer(32'h0300_0010, 32'h0400_0100, 4, c, "R5 R10 word inc");
  endtask

  task automatic t_low_reuse();
    logic [7:0] c;
    c = mk_ctrl(2'b00, 2'b00, 1'b1, 2'b00);
    start(32'h0300_0040, 32'h0400_0000, 1, c);
    wait_idle();
    expect_xfer(32'h0300_0040, 32'h0400_0000, 1, c, "R6 word load");
    c = mk_ctrl(2'b00, 2'b00, 1'b0, 2'b00);
    start(32'h0000_0100, 32'h0300_0202, 2, c);
    wait_idle();
    expect_xfer(32'h0000_0100, 32'h0300_0202, 2, c, "R6 R8 reuse lanes");
  endtask

  task automatic t_half_mirror();
    logic [7:0] c;
    c = mk_ctrl(2'b00, 2'b00, 1'b0, 2'b00);
    start(32'h0300_0082, 32'h0300_0302, 3, c);
    wait_idle();
    expect_xfer(32'h0300_0082, 32'h0300_0302, 3, c, "R7 R8 half mirror");
  endtask

  task automatic t_dec_fixed();
    logic [7:0] c;
    c = mk_ctrl(2'b10, 2'b01, 1'b1, 2'b00);
    start(32'h0300_0107, 32'h0500_0003, 3, c);
    wait_idle();
    expect_xfer(32'h0300_0107, 32'h0500_0003, 3, c, "R5 dec fixed");
  endtask

  task automatic t_mask();
    logic [7:0] c;
    c = mk_ctrl(2'b00, 2'b00, 1'b1, 2'b00);
    start(32'hFFFF_FFF0, 32'hF800_0020, 1, c);
    wait_idle();
    chk(rd_a[0] == 32'h07FF_FFF0, "R1 src mask", rd_a[0], 32'h07FF_FFF0);
    chk(wr_a[0] == 32'h0000_0020, "R1 dst mask", wr_a[0], 32'h0000_0020);
  endtask

  task automatic t_trigger();
    logic [7:0] c;
    c = mk_ctrl(2'b00, 2'b00, 1'b1, 2'b01);
    clear_log();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && wr_n == 0, "R4 trig ignored idle", wr_n, 0);
    start(32'h0300_0400, 32'h0400_0400, 2, c);
    repeat (20) @(negedge clk);
    chk(!busy && rd_n == 0 && wr_n == 0, "R4 armed waits", rd_n + wr_n, 0);
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    wait_idle();
    expect_xfer(32'h0300_0400, 32'h0400_0400, 2, c, "R4 triggered");
  endtask

  task automatic t_snapshot();
    logic [7:0] c;
    c = mk_ctrl(2'b00, 2'b00, 1'b1, 2'b00);
    stall_en = 1'b1;
    start(32'h0300_0500, 32'h0400_0500, 4, c);
    chk(busy, "R4 immediate start", busy, 1);
    reg_write(2'd0, 32'h0300_0900);
    reg_write(2'd1, 32'h0400_0900);
    reg_write(2'd2, 32'd9);
    wait_idle();
    stall_en = 1'b0;
    expect_xfer(32'h0300_0500, 32'h0400_0500, 4, c, "R3 snapshot");
  endtask

  task automatic t_zero_count();
    logic [7:0] c;
    c = mk_ctrl(2'b10, 2'b10, 1'b0, 2'b00);
    start(32'h0000_0010, 32'h0300_0010, 0, c);
    wait_idle();
    expect_xfer(32'h0000_0010, 32'h0300_0010, 0, c, "R2 zero count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reset_latch();
    t_word_inc();
    t_low_reuse();
    t_half_mirror();
    t_dec_fixed();
    t_mask();
    t_trigger();
    t_snapshot();
    t_zero_count();
    summary();
    $finish;
  end
endmodule